// File: doc/BRIEF.md
# Multi-Port GPIO Controller with Edge Interrupts

The block groups general-purpose pins into ports of eight, with the number of ports set by a parameter. Software reaches it over a plain 32-bit register bus: one write strobe, one read strobe and a word address. Read data is registered and is valid one cycle after the read strobe. Each pin has an output value, a two-bit drive style and a pull-up control. Each pin also has an input path, with an optional two-flop synchroniser in the read path, and an edge interrupt. The edge polarity is chosen per pin, and software can force an interrupt.

Each port drives one interrupt line. The line is registered and is the OR of the pins' latched events masked by their enables. A global control word at offset 0x00 holds two writable enable bits, the core version and the port count. Pad-facing controls are registered: an output value, an output enable and a pull-up enable for every pin. These controls are meant to feed external pad cells.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every pin is an input (pad_oe low), every pull-up is enabled (pad_pu_en high), every irq line is low, and every per-port register reads 0.
- R2: The word at offset 0x00 reads bit 0 as clock-request enable and bit 1 as synchroniser-select enable, both writable. Bits 8:2 read VERSION_ID and bits 15:9 read NUM_PORTS; these fields and all other bits ignore writes.
- R3: Port p's registers sit at p*0x30 plus an offset: input 0x04, output 0x08, mode 0x0C, pull-up disable 0x10, event 0x14, enable 0x18, force 0x1C, polarity 0x20. A write to one port's register leaves every other port unchanged.
- R4: The mode register holds a 2-bit code for pin k in bits 2k+1:2k. Code 0 is input (oe 0, out 0). Code 1 is push-pull (oe 1, out = data). Code 2 is open-drain (oe = NOT data, out 0). Code 3 is open-source (oe = data, out 1). The pads follow two cycles after the write.
- R5: A 1 in bit k of the pull-up register turns that pin's pad_pu_en off; a 0 keeps it on.
- R6: With synchroniser-select 0, the input register reads pad_in as sampled on the read edge. With it at 1, the input register reads the value after two flops.
- R7: Polarity bit 1 latches the pin's event on a rising synchronised input and bit 0 on a falling one. The opposite edge latches nothing.
- R8: Writing 1 to an event bit clears it; writing 0 leaves it. A new edge in the same cycle wins over the clear.
- R9: Writing 1 to a force bit sets the matching event bit on the next edge. The force bit reads 1 for that one cycle only.
- R10: irq[p] is registered and equals the OR over port p's eight pins of event AND enable in the previous cycle.
- R11: The input register ignores writes. Bits above 15 of the mode word, above 7 of the other per-port words, and any unmapped address read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| pad_in | input | 8*NUM_PORTS | Levels seen at the pins |
| pad_out | output | 8*NUM_PORTS | Value to drive on each pin |
| pad_oe | output | 8*NUM_PORTS | Drive enable for each pin |
| pad_pu_en | output | 8*NUM_PORTS | Pull-up enable for each pin |
| irq | output | NUM_PORTS | One interrupt line per port |

## Verification
The bench sets up one port with all four drive styles and then flips the data byte. A design that swaps open-drain and open-source, or drives an input pin, would show the wrong enable pattern. Edge tests drive both edge directions on a pin of each polarity, so a design with the polarity sense inverted latches on the wrong edge. They also confirm that writing 0 to the event register leaves it unchanged. The force test reads the force bit back twice in a row; a design that fails to self-clear it would show 1 in the second read. Raising a pin in the same cycle as the read shows whether the synchroniser select really picks the raw or the two-flop path. Port-offset writes catch a bank stride or offset that aliases one port onto another.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int PINS_PER_PORT = 8;
  localparam int BANK_STRIDE   = 'h30;
  localparam int OFF_DIN  = 'h04;
  localparam int OFF_DOUT = 'h08;
  localparam int OFF_MODE = 'h0C;
  localparam int OFF_PULL = 'h10;
  localparam int OFF_EVT  = 'h14;
  localparam int OFF_IEN  = 'h18;
  localparam int OFF_FRC  = 'h1C;
  localparam int OFF_EDG  = 'h20;

  typedef enum logic [1:0] {
    MODE_IN = 2'd0,
    MODE_PP = 2'd1,
    MODE_OD = 2'd2,
    MODE_OS = 2'd3
  } pin_mode_e;

  typedef struct packed {
    logic din;
    logic dout;
    logic mode;
    logic pull;
    logic evt;
    logic ien;
    logic frc;
    logic edg;
  } bank_sel_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_port_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  bank_sel_t   sel,
  input  logic [15:0] wdata,
  input  logic [7:0]  pin_sync,
  input  logic [7:0]  pin_view,
  output logic [31:0] rd_word,
  output logic        irq,
  output logic [7:0]  pad_out,
  output logic [7:0]  pad_oe,
  output logic [7:0]  pad_pu_en,
  output logic [15:0] mode_q,
  output logic [7:0]  evt_q,
  output logic [7:0]  ien_q,
  output logic [7:0]  frc_q,
  output logic [7:0]  pudis_q
);
  logic [7:0] dout_q, edg_q, prev_q;
  logic [7:0] evt_clr, evt_hit, evt_nxt;
  logic [7:0] drv_oe, drv_val;

  assign evt_clr = (wr_en && sel.evt) ? wdata[7:0] : 8'h00;
  assign evt_hit = (edg_q & pin_sync & ~prev_q) | (~edg_q & ~pin_sync & prev_q);
  assign evt_nxt = (evt_q & ~evt_clr) | evt_hit | frc_q;

  for (genvar k = 0; k < PINS_PER_PORT; k++) begin : g_drv
    pin_mode_e m;
    assign m = pin_mode_e'(mode_q[2*k +: 2]);
    always_comb begin
      case (m)
        MODE_PP: begin drv_oe[k] = 1'b1;       drv_val[k] = dout_q[k]; end
        MODE_OD: begin drv_oe[k] = ~dout_q[k]; drv_val[k] = 1'b0;      end
        MODE_OS: begin drv_oe[k] = dout_q[k];  drv_val[k] = 1'b1;      end
        default: begin drv_oe[k] = 1'b0;       drv_val[k] = 1'b0;      end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q    <= '0;
      mode_q    <= '0;
      pudis_q   <= '0;
      ien_q     <= '0;
      edg_q     <= '0;
      frc_q     <= '0;
      evt_q     <= '0;
      prev_q    <= '0;
      irq       <= 1'b0;
      pad_out   <= '0;
      pad_oe    <= '0;
      pad_pu_en <= '1;
    end else begin
      if (wr_en && sel.dout) dout_q  <= wdata[7:0];
      if (wr_en && sel.mode) mode_q  <= wdata;
      if (wr_en && sel.pull) pudis_q <= wdata[7:0];
      if (wr_en && sel.ien)  ien_q   <= wdata[7:0];
      if (wr_en && sel.edg)  edg_q   <= wdata[7:0];
      frc_q     <= (wr_en && sel.frc) ? wdata[7:0] : 8'h00;
      evt_q     <= evt_nxt;
      prev_q    <= pin_sync;
      irq       <= |(evt_q & ien_q);
      pad_out   <= drv_val;
      pad_oe    <= drv_oe;
      pad_pu_en <= ~pudis_q;
    end
  end

  always_comb begin
    rd_word = 32'h0;
    unique case (1'b1)
      sel.din:  rd_word = {24'h0, pin_view};
      sel.dout: rd_word = {24'h0, dout_q};
      sel.mode: rd_word = {16'h0, mode_q};
      sel.pull: rd_word = {24'h0, pudis_q};
      sel.evt:  rd_word = {24'h0, evt_q};
      sel.ien:  rd_word = {24'h0, ien_q};
      sel.frc:  rd_word = {24'h0, frc_q};
      sel.edg:  rd_word = {24'h0, edg_q};
      default:  rd_word = 32'h0;
    endcase
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int          NUM_PORTS  = 5,
  parameter int          ADDR_W     = 12,
  parameter logic [6:0]  VERSION_ID = 7'd3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  input  logic [PINS_PER_PORT*NUM_PORTS-1:0] pad_in,
  output logic [PINS_PER_PORT*NUM_PORTS-1:0] pad_out,
  output logic [PINS_PER_PORT*NUM_PORTS-1:0] pad_oe,
  output logic [PINS_PER_PORT*NUM_PORTS-1:0] pad_pu_en,
  output logic [NUM_PORTS-1:0]          irq
);
  localparam int NUM_PINS = PINS_PER_PORT * NUM_PORTS;
  localparam logic [6:0] PORT_COUNT = 7'(NUM_PORTS);

  logic [1:0]          ctrl_q;
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] pin_view;
  logic [31:0]         port_rd [NUM_PORTS];
  logic [31:0]         rd_mux;
  logic                ctrl_hit;
  logic                lint_unused_wdata;

  logic [2*NUM_PINS-1:0] mode_all;
  logic [NUM_PINS-1:0]   evt_all, ien_all, frc_all, pu_dis_all;

  assign lint_unused_wdata = ^bus_wdata[31:16];
  assign ctrl_hit = (bus_addr == '0);

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= 2'b00;
    else if (bus_wr && ctrl_hit) ctrl_q <= bus_wdata[1:0];
  end

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pin_sync)
  );

  assign pin_view = ctrl_q[1] ? pin_sync : pad_in;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int BASE = p * BANK_STRIDE;
    bank_sel_t sel;
    assign sel.din  = (bus_addr == ADDR_W'(BASE + OFF_DIN));
    assign sel.dout = (bus_addr == ADDR_W'(BASE + OFF_DOUT));
    assign sel.mode = (bus_addr == ADDR_W'(BASE + OFF_MODE));
    assign sel.pull = (bus_addr == ADDR_W'(BASE + OFF_PULL));
    assign sel.evt  = (bus_addr == ADDR_W'(BASE + OFF_EVT));
    assign sel.ien  = (bus_addr == ADDR_W'(BASE + OFF_IEN));
    assign sel.frc  = (bus_addr == ADDR_W'(BASE + OFF_FRC));
    assign sel.edg  = (bus_addr == ADDR_W'(BASE + OFF_EDG));

    gpio_bank u_bank (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (bus_wr),
      .sel       (sel),
      .wdata     (bus_wdata[15:0]),
      .pin_sync  (pin_sync[p*8 +: 8]),
      .pin_view  (pin_view[p*8 +: 8]),
      .rd_word   (port_rd[p]),
      .irq       (irq[p]),
      .pad_out   (pad_out[p*8 +: 8]),
      .pad_oe    (pad_oe[p*8 +: 8]),
      .pad_pu_en (pad_pu_en[p*8 +: 8]),
      .mode_q    (mode_all[p*16 +: 16]),
      .evt_q     (evt_all[p*8 +: 8]),
      .ien_q     (ien_all[p*8 +: 8]),
      .frc_q     (frc_all[p*8 +: 8]),
      .pudis_q   (pu_dis_all[p*8 +: 8])
    );
  end

  always_comb begin
    rd_mux = ctrl_hit ? {16'h0, PORT_COUNT, VERSION_ID, ctrl_q} : 32'h0;
    for (int p = 0; p < NUM_PORTS; p++) rd_mux = rd_mux | port_rd[p];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= 32'h0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int NUM_PORTS = 5
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_PORTS-1:0]      irq,
  input logic [8*NUM_PORTS-1:0]    pad_oe,
  input logic [8*NUM_PORTS-1:0]    pad_pu_en,
  input logic [16*NUM_PORTS-1:0]   mode_all,
  input logic [8*NUM_PORTS-1:0]    evt_all,
  input logic [8*NUM_PORTS-1:0]    ien_all,
  input logic [8*NUM_PORTS-1:0]    frc_all,
  input logic [8*NUM_PORTS-1:0]    pu_dis_all
);
  localparam int NP = 8 * NUM_PORTS;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (irq == '0 && pad_oe == '0 && pad_pu_en == '1)); // R1

  AST_PULLUP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    pad_pu_en == ~$past(pu_dis_all)); // R5

  AST_FORCE_SETS_EVENT: assert property (@(posedge clk) disable iff (rst)
    (frc_all != '0) |=> ((evt_all & $past(frc_all)) == $past(frc_all))); // R9

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_irq
    AST_IRQ_MASKED_OR: assert property (@(posedge clk) disable iff (rst)
      irq[p] == $past(|(evt_all[p*8 +: 8] & ien_all[p*8 +: 8]))); // R10
  end

  for (genvar i = 0; i < NP; i++) begin : g_pin
    AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
      ($past(mode_all[2*i +: 2]) == 2'd0) |-> !pad_oe[i]); // R4
  end
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq        (irq),
  .pad_oe     (pad_oe),
  .pad_pu_en  (pad_pu_en),
  .mode_all   (mode_all),
  .evt_all    (evt_all),
  .ien_all    (ien_all),
  .frc_all    (frc_all),
  .pu_dis_all (pu_dis_all)
);

// File: tb/gpio_port_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb;
  localparam int NUM_PORTS = 5;
  localparam int NP = 8 * NUM_PORTS;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe, pad_pu_en;
  logic [NUM_PORTS-1:0] irq;

  int checks = 0;
  int errors = 0;
  logic rv = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  gpio_port_ctrl #(.NUM_PORTS(NUM_PORTS), .ADDR_W(12), .VERSION_ID(7'd3)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu_en(pad_pu_en), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares read data the cycle after the strobe
  always @(posedge clk) rv <= bus_rd;
  always @(negedge clk) begin
    if (rv) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3 unexpected read act=%0h exp=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, 64'(bus_rdata), 64'(e));
      end
    end
  end

  // all tasks start and end at a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R1 watchdog act=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 pad_oe", 64'(pad_oe), 64'h0);
    chk("R1 pad_pu_en", 64'(pad_pu_en), {24'h0, 40'hFF_FFFF_FFFF});
    chk("R1 irq", 64'(irq), 64'h0);
    rd(12'h06C, 32'h0, "R1 port2 mode");
    rd(12'h0D4, 32'h0, "R1 port4 event");
    // R2 control word
    rd(12'h000, 32'h0000_0A0C, "R2 ctrl reset");
    wr(12'h000, 32'h0000_0003);
    rd(12'h000, 32'h0000_0A0F, "R2 ctrl enables");
    wr(12'h000, 32'hFFFF_FFFC);
    rd(12'h000, 32'h0000_0A0C, "R2 ctrl ro fields");
    // R3 bank stride and offsets
    wr(12'h038, 32'h0000_00A5);
    wr(12'h0C8, 32'h0000_003C);
    rd(12'h038, 32'h0000_00A5, "R3 port1 dout");
    rd(12'h0C8, 32'h0000_003C, "R3 port4 dout");
    rd(12'h008, 32'h0000_0000, "R3 port0 dout untouched");
    // R4 drive modes on port1: pin0 PP, pin1 OD, pin2 OS, pin3 IN, pins4-7 PP
    wr(12'h03C, 32'h0000_5539);
    rd(12'h03C, 32'h0000_5539, "R3 port1 mode");
    idle(3);
    chk("R4 oe port1 data A5", 64'(pad_oe[15:8]), 64'hF7);
    chk("R4 out port1 data A5", 64'(pad_out[15:8]), 64'hA5);
    chk("R4 other ports idle", 64'({pad_oe[39:16], pad_oe[7:0]}), 64'h0);
    wr(12'h038, 32'h0000_005A);
    idle(3);
    chk("R4 oe port1 data 5A", 64'(pad_oe[15:8]), 64'hF1);
    chk("R4 out port1 data 5A", 64'(pad_out[15:8]), 64'h54);
    // R5 pull-up disable on port3
    wr(12'h0A0, 32'h0000_000F);
    idle(3);
    chk("R5 pull-ups", 64'(pad_pu_en), {24'h0, 40'hFF_F0FF_FFFF});
    // R6 raw vs synchronised input view
    wr(12'h000, 32'h0000_0000);
    pad_in[0] = 1'b1;
    rd(12'h004, 32'h0000_0001, "R6 raw view same cycle");
    wr(12'h000, 32'h0000_0002);
    idle(2);
    pad_in[1] = 1'b1;
    rd(12'h004, 32'h0000_0001, "R6 sync view lags");
    idle(3);
    rd(12'h004, 32'h0000_0003, "R6 sync view settled");
    // R7 polarity on port2: pin16 rising, pin17 falling; both enabled
    wr(12'h080, 32'h0000_0001);
    wr(12'h078, 32'h0000_0003);
    idle(2);
    pad_in[16] = 1'b1;
    idle(6);
    rd(12'h074, 32'h0000_0001, "R7 rising latched");
    chk("R10 irq port2 set", 64'(irq), 64'h04);
    pad_in[17] = 1'b1;
    idle(6);
    rd(12'h074, 32'h0000_0001, "R7 rise ignored on falling pin");
    // R8 write-one clear
    wr(12'h074, 32'h0000_0001);
    idle(3);
    rd(12'h074, 32'h0000_0000, "R8 cleared");
    chk("R10 irq port2 cleared", 64'(irq), 64'h00);
    pad_in[16] = 1'b0;
    idle(6);
    rd(12'h074, 32'h0000_0000, "R7 fall ignored on rising pin");
    pad_in[17] = 1'b0;
    idle(6);
    rd(12'h074, 32'h0000_0002, "R7 falling latched");
    wr(12'h074, 32'h0000_0000);
    rd(12'h074, 32'h0000_0002, "R8 zero write keeps");
    wr(12'h074, 32'h0000_0002);
    idle(2);
    rd(12'h074, 32'h0000_0000, "R8 second clear");
    // R9 force on port4 pin7, enable off
    wr(12'h0DC, 32'h0000_0080);
    rd(12'h0DC, 32'h0000_0080, "R9 force visible one cycle");
    rd(12'h0DC, 32'h0000_0000, "R9 force self-clears");
    rd(12'h0D4, 32'h0000_0080, "R9 event set by force");
    idle(2);
    chk("R10 masked irq stays low", 64'(irq), 64'h00);
    wr(12'h0D8, 32'h0000_0080);
    idle(3);
    chk("R10 irq port4 enabled", 64'(irq), 64'h10);
    // R11 read-only input word and unused bits
    wr(12'h004, 32'h0000_00FF);
    idle(1);
    rd(12'h004, 32'h0000_0003, "R11 input ignores write");
    wr(12'h018, 32'hFFFF_FFFF);
    rd(12'h018, 32'h0000_00FF, "R11 enable upper bits zero");
    wr(12'h00C, 32'hFFFF_FFFF);
    rd(12'h00C, 32'h0000_FFFF, "R11 mode upper bits zero");
    rd(12'h02C, 32'h0000_0000, "R11 unmapped reads zero");
    idle(3);
    chk("R11 scoreboard drained", 64'(exp_q.size()), 64'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule